// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over several clock cycles and returns the full 64-bit product. It keeps the datapath narrow: a multiplicand register, an adder only as wide as one operand, and one double-width product register. The multiplier operand does not get a register of its own. It is placed in the low half of the product register, and each step consumes its lowest bit while the partial sum grows into the high half.

A one-cycle `start` pulse, seen while the block is idle or finished, captures both operands. The block then runs one add-and-shift iteration per clock. On each iteration it tests the low bit of the product register, adds the multiplicand to the high half when that bit is set, and shifts the whole register right by one place. The adder's carry-out enters at the top. After the last iteration `done` rises, and it stays high with a frozen product until the next accepted `start`. Control and status are plain level pins. The block has no stream handshake and does not stall.

Top module: `seq_mult`

## Requirements
- R1: While reset is high, and on the first clock after it, `done` is 0 and `product` is all zeros.
- R2: A `start` accepted on a rising edge captures `op_a` and `op_b`. `done` rises on the 32nd rising edge after that edge, one iteration per edge.
- R3: When `done` is 1, `product` equals the unsigned 64-bit value of `op_a` times `op_b` as captured at the accepted start. This holds for operands whose partial sums carry out of the 32-bit adder, such as 0xFFFFFFFF times 0xFFFFFFFF = 0xFFFFFFFE00000001.
- R4: While an operation is running, `start` and any change on `op_a` or `op_b` have no effect on the result or on when `done` rises.
- R5: Once `done` is 1 it stays 1, and `product` keeps its value, on every edge until `start` is seen.
- R6: A `start` seen while `done` is 1 clears `done` on that edge and begins a new operation with the operands present then.
- R7: A zero operand on either side gives a zero product. A multiplier of 1 gives the multiplicand, and a multiplicand of 1 gives the multiplier.
- R8: Every operation takes exactly 32 iterations, whatever the operand values. There is no early finish when the upper multiplier bits are zero. `done` is never high while iterations are still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse; ignored while an operation is running |
| op_a | input | 32 | Multiplicand, sampled on an accepted start |
| op_b | input | 32 | Multiplier, sampled on an accepted start |
| product | output | 64 | Product register; valid while done is high |
| done | output | 1 | High from the end of an operation until the next accepted start |

## Verification
The assertions assume that `start` and reset are known levels on every edge. They make no assumption about the operands between starts, because the block samples them only on an accepted start. The stimulus drives every input at the falling clock edge. After each launch it deliberately scrambles the operands and pulses `start` again in the middle of a run, to show that such activity stays invisible. Restarts are issued both the cycle `done` rises and several cycles later, so the hold rule and the restart rule are each exercised.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_t;
endpackage

// File: rtl/mul_add.sv
module mul_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         en,
  output logic [W:0]   sum
);
  logic [W-1:0] y_gated;
  always_comb begin
    y_gated = en ? y : '0;
    sum     = {1'b0, x} + {1'b0, y_gated};
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt
);
  import mul_pkg::*;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          cnt <= cnt + CW'(1);
          if (cnt == LAST) state <= ST_FIN;
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

  always_comb begin
    busy = (state == ST_RUN);
    done = (state == ST_FIN);
    step = busy;
    load = start && !busy;
  end
endmodule

// File: rtl/mul_path.sv
module mul_path #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand;
  logic [W:0]   sum;

  mul_add #(.W(W)) u_add (
    .x   (prod[2*W-1:W]),
    .y   (mcand),
    .en  (prod[0]),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      prod  <= '0;
    end else if (load) begin
      mcand <= a;
      prod  <= {{W{1'b0}}, b};
    end else if (step) begin
      prod  <= {sum, prod[W-1:1]};
    end
  end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int CW = $clog2(W);

  logic          load;
  logic          step;
  logic          busy;
  logic [CW-1:0] cnt;

  mul_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done),
    .cnt   (cnt)
  );

  mul_path #(.W(W)) u_path (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step),
    .a    (op_a),
    .b    (op_b),
    .prod (product)
  );
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           done,
  input logic           busy,
  input logic [CW-1:0]  cnt,
  input logic [2*W-1:0] product
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && product == '0));

  p_count_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CW'(W - 1)) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));

  p_finish_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == CW'(W - 1)) |=> done);

  p_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && $past(cnt) == CW'(W - 1)));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done}));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(product)));

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (busy && !done));
endmodule

bind seq_mult seq_mult_chk #(.W(W), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .busy    (busy),
  .cnt     (cnt),
  .product (product)
);

// File: tb/tb_seq_mult.sv
module tb_seq_mult;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [63:0] product;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string req = "R2";

  seq_mult dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done)
  );

  always #2 clk = ~clk;

  // Behavioural reference: busy flag, iteration count, latched operands.
  bit              m_busy, m_done;
  int              m_iter;
  longint unsigned m_a, m_b;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_iter <= 0;
    end else if (m_busy) begin
      m_iter <= m_iter + 1;
      if (m_iter + 1 == 32) begin
        m_busy <= 0; m_done <= 1;
      end
    end else if (start) begin
      m_busy <= 1; m_done <= 0; m_iter <= 0;
      m_a <= longint'(op_a); m_b <= longint'(op_b);
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (done !== m_done) begin
        errors++;
        $display("FAIL %s done: actual %0b expected %0b", req, done, m_done);
      end
      if (m_done) begin
        longint unsigned exp_p;
        exp_p = m_a * m_b;
        checks++;
        if (product !== exp_p) begin
          errors++;
          $display("FAIL R3 (%s) product: actual %h expected %h", req, product, exp_p);
        end
      end
    end
  end

  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0; op_a = $urandom(); op_b = $urandom();
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input int extra);
    launch(a, b);
    repeat (31 + extra) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || product !== 64'd0) begin
      errors++;
      $display("FAIL R1 reset: actual done=%0b product=%h expected 0/0", done, product);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || product !== 64'd0) begin
      errors++;
      $display("FAIL R1 after reset: actual done=%0b product=%h expected 0/0", done, product);
    end

    req = "R7"; run(32'd0, 32'hDEADBEEF, 2);
    req = "R7"; run(32'h12345678, 32'd0, 2);
    req = "R7"; run(32'd1, 32'hCAFEF00D, 2);
    req = "R7"; run(32'h89ABCDEF, 32'd1, 2);
    req = "R3"; run(32'hFFFFFFFF, 32'hFFFFFFFF, 2);
    req = "R8"; run(32'hFFFFFFFF, 32'd1, 2);

    // R4: start pulses and operand churn mid-run are ignored.
    req = "R4";
    launch(32'h0000_BEEF, 32'h0001_0003);
    repeat (9) @(negedge clk);
    start = 1'b1; op_a = 32'hFFFFFFFF; op_b = 32'h7;
    @(negedge clk);
    start = 1'b0;
    repeat (22) @(negedge clk);

    // R5: hold with no start for several cycles.
    req = "R5";
    repeat (6) @(negedge clk);

    // R6: restart in the very cycle done is seen high.
    req = "R6";
    run(32'h80000000, 32'h80000001, 0);
    launch(32'h00000003, 32'h00000005);
    repeat (31) @(negedge clk);

    req = "R2";
    for (int i = 0; i < 20; i++) run($urandom(), $urandom(), i % 3);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule